// File: doc/BRIEF.md
# Code Memory Wait-State and Program-Write Controller

This block sits between an 8051-style processor core and its program memory. Every instruction fetch and every MOVC table read is stretched by a programmable number of clocks. That count comes from a small wait-state register, so slow code storage can be used without changing the core. The core raises a request with an access kind. It keeps the request high until the block pulses `core_ready` for one cycle.

A program-write enable bit, held in the power-control register, decides where MOVX writes go. When the bit is set, MOVX writes are redirected into code memory. The write address comes from the data pointer or from the port-2 byte joined with an indirect register byte, and the accumulator is the data. The code-write strobe has one clock of setup and one clock of hold around it. Its width is set by a stretch field in a clock-control register, not by the wait-state register. When the bit is clear, MOVX writes leave on a one-cycle data-memory bus and the code strobe stays quiet.

Every setting is captured when a request is accepted. A register write made while an access is running therefore only affects the next access.

Top module: `code_wait_ctrl`

## Requirements
- R1: After reset the wait-state register reads 0x07, the power-control register reads 0x00 and the clock-control register reads 0x01. `core_ready`, `code_rd`, `code_we` and `xdata_we` are all low.
- R2: The wait-state register is at SFR address 0x92. Bits 2:0 are stored and bits 7:3 always read 0.
- R3: A fetch (`req_kind`=00) or MOVC read (`req_kind`=01) keeps `code_rd` high for exactly 4+min(N,4) cycles, where N is the wait-state value. `code_addr` equals `req_addr` and stays stable throughout. `core_ready` is high only in the last of those cycles.
- R4: The power-control register is at SFR address 0x87. Bits 7:3 are stored, bit 4 is the program-write enable, and bits 2:0 always read 0 whatever is written.
- R5: With program-write enable at 1, a `req_kind`=10 write puts `dptr` on `code_addr` and `acc` on `code_wdata`.
- R6: With program-write enable at 1, a `req_kind`=11 write puts {`p2`,`rx`} on `code_addr`, with `p2` as bits 15:8 and `rx` as bits 7:0.
- R7: A code write has one setup cycle with `code_we` low. Then `code_we` is high for 2+S cycles, where S is bits 2:0 of the clock-control register at SFR address 0x8E. Then comes one hold cycle with `core_ready` high, for 4+S cycles in total. Address and data are constant over all of them.
- R8: With program-write enable at 0, a MOVX write raises `xdata_we` for one cycle, with the request's address and `acc` on the data-memory bus and `core_ready` high in that same cycle. `code_we` stays low and the wait-state value has no effect.
- R9: The wait-state, stretch and enable values are sampled when a request is accepted. An SFR write during an access changes only later accesses.
- R10: `core_ready` is never high on two consecutive cycles. A request held high while an access is running starts nothing extra.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_we | input | 1 | SFR write strobe |
| sfr_addr | input | 8 | SFR address for read and write |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data for `sfr_addr` |
| req_valid | input | 1 | Core access request, held until `core_ready` |
| req_kind | input | 2 | 00 fetch, 01 MOVC, 10 MOVX write via data pointer, 11 MOVX write via port/register |
| req_addr | input | 16 | Read address for fetch and MOVC |
| dptr | input | 16 | Data pointer value |
| p2 | input | 8 | Port-2 byte, high address half |
| rx | input | 8 | Indirect register byte, low address half |
| acc | input | 8 | Accumulator, write data |
| core_ready | output | 1 | One-cycle completion pulse |
| code_addr | output | 16 | Code memory address |
| code_wdata | output | 8 | Code memory write data |
| code_rd | output | 1 | Code memory read enable |
| code_we | output | 1 | Code memory write strobe |
| xdata_addr | output | 16 | Data memory address |
| xdata_wdata | output | 8 | Data memory write data |
| xdata_we | output | 1 | Data memory write strobe |

## Verification
A corrupted cycle counter or latched setting shows up in the very access where it occurs. `core_ready` arrives early or late, or the run of `code_rd` or `code_we` has the wrong length, and each access is timed edge by edge against the register values the bench last wrote. A wrong latched address or data byte appears on the memory buses in the same cycles. A damaged SFR bit is caught by the next read-back. A state machine stuck outside idle stops `core_ready` entirely, and the check on that access catches it.

// File: rtl/cwc_pkg.sv
package cwc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_READ, ST_SETUP, ST_STROBE, ST_HOLD, ST_XWR
   } cwc_state_t;

   localparam logic [1:0] KIND_FETCH = 2'b00;
   localparam logic [1:0] KIND_MOVC  = 2'b01;
   localparam logic [1:0] KIND_WDPTR = 2'b10;
   localparam logic [1:0] KIND_WPRX  = 2'b11;

   function automatic int unsigned read_cycles(input int unsigned ws,
                                               input int unsigned base,
                                               input int unsigned extra_max);
      return base + ((ws > extra_max) ? extra_max : ws);
   endfunction
endpackage

// File: rtl/cwc_sfr_regs.sv
module cwc_sfr_regs #(
   parameter int          SFR_AW     = 8,
   parameter int          SFR_DW     = 8,
   parameter int          WS_W       = 3,
   parameter int          STR_W      = 3,
   parameter int          PWE_BIT    = 4,
   parameter int          RSVD_LOW   = 3,
   parameter logic [7:0]  WS_ADDR    = 8'h92,
   parameter logic [7:0]  PC_ADDR    = 8'h87,
   parameter logic [7:0]  CK_ADDR    = 8'h8E,
   parameter logic [7:0]  WS_RESET   = 8'h07,
   parameter logic [7:0]  PC_RESET   = 8'h00,
   parameter logic [7:0]  CK_RESET   = 8'h01,
   parameter bit          REG_READ   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sfr_we,
   input  logic [SFR_AW-1:0] sfr_addr,
   input  logic [SFR_DW-1:0] sfr_wdata,
   output logic [SFR_DW-1:0] sfr_rdata,
   output logic [WS_W-1:0]   ws_val,
   output logic [STR_W-1:0]  str_val,
   output logic              pwe
);
   localparam int PC_KEEP = SFR_DW - RSVD_LOW;

   initial begin
      assert (WS_W  < SFR_DW) else $error("WS_W must fit below SFR width");
      assert (STR_W < SFR_DW) else $error("STR_W must fit below SFR width");
      assert (PWE_BIT >= RSVD_LOW && PWE_BIT < SFR_DW)
         else $error("PWE_BIT must sit in the stored part of power control");
   end

   logic [WS_W-1:0]    ws_q;
   logic [STR_W-1:0]   ck_q;
   logic [PC_KEEP-1:0] pc_q;
   logic [SFR_DW-1:0]  rd_mux;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ws_q <= WS_RESET[WS_W-1:0];
         ck_q <= CK_RESET[STR_W-1:0];
         pc_q <= PC_RESET[SFR_DW-1:RSVD_LOW];
      end else if (sfr_we) begin
         if (sfr_addr == WS_ADDR[SFR_AW-1:0]) ws_q <= sfr_wdata[WS_W-1:0];
         if (sfr_addr == CK_ADDR[SFR_AW-1:0]) ck_q <= sfr_wdata[STR_W-1:0];
         if (sfr_addr == PC_ADDR[SFR_AW-1:0]) pc_q <= sfr_wdata[SFR_DW-1:RSVD_LOW];
      end
   end

   always_comb begin
      rd_mux = '0;
      if (sfr_addr == WS_ADDR[SFR_AW-1:0])
         rd_mux = {{(SFR_DW-WS_W){1'b0}}, ws_q};
      else if (sfr_addr == CK_ADDR[SFR_AW-1:0])
         rd_mux = {{(SFR_DW-STR_W){1'b0}}, ck_q};
      else if (sfr_addr == PC_ADDR[SFR_AW-1:0])
         rd_mux = {pc_q, {RSVD_LOW{1'b0}}};
   end

   generate
      if (REG_READ) begin : g_rd_reg
         logic [SFR_DW-1:0] rd_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rd_q <= '0;
            else        rd_q <= rd_mux;
         end
         assign sfr_rdata = rd_q;
      end else begin : g_rd_comb
         assign sfr_rdata = rd_mux;
      end
   endgenerate

   assign ws_val  = ws_q;
   assign str_val = ck_q;
   assign pwe     = pc_q[PWE_BIT-RSVD_LOW];
endmodule

// File: rtl/cwc_addr_sel.sv
module cwc_addr_sel #(
   parameter int ADDR_W = 16
) (
   input  logic [1:0]          kind,
   input  logic [ADDR_W-1:0]   rd_addr,
   input  logic [ADDR_W-1:0]   dptr,
   input  logic [ADDR_W/2-1:0] hi_byte,
   input  logic [ADDR_W/2-1:0] lo_byte,
   output logic [ADDR_W-1:0]   addr
);
   import cwc_pkg::*;

   initial begin
      assert (ADDR_W % 2 == 0) else $error("ADDR_W must be even");
   end

   always_comb begin
      unique case (kind)
         KIND_WDPTR: addr = dptr;
         KIND_WPRX:  addr = {hi_byte, lo_byte};
         default:    addr = rd_addr;
      endcase
   end
endmodule

// File: rtl/cwc_seq.sv
module cwc_seq #(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 8,
   parameter int WS_W       = 3,
   parameter int STR_W      = 3,
   parameter int READ_BASE  = 4,
   parameter int READ_EXTRA = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] data_in,
   input  logic [WS_W-1:0]   ws_val,
   input  logic [STR_W-1:0]  str_val,
   input  logic              pwe,
   output logic              core_ready,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_data,
   output logic              code_rd,
   output logic              code_we,
   output logic              xdata_we
);
   import cwc_pkg::*;

   localparam int READ_MAX = READ_BASE + READ_EXTRA;
   localparam int STR_MAX  = 2 + (1 << STR_W) - 1;
   localparam int CNT_W    = $clog2(((READ_MAX > STR_MAX) ? READ_MAX : STR_MAX) + 1);

   initial begin
      assert (READ_BASE >= 1) else $error("READ_BASE must be at least 1");
      assert (READ_EXTRA >= 0) else $error("READ_EXTRA must not be negative");
   end

   cwc_state_t        state;
   logic [CNT_W-1:0]  cnt;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic [CNT_W-1:0]  rd_len_m1;
   logic [CNT_W-1:0]  str_len_m1;

   always_comb begin
      rd_len_m1  = CNT_W'(read_cycles(int'(ws_val), READ_BASE, READ_EXTRA) - 1);
      str_len_m1 = CNT_W'(1 + int'(str_val));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         addr_q <= '0;
         data_q <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (req_valid) begin
               addr_q <= addr_in;
               data_q <= data_in;
               if (!req_kind[1]) begin
                  state <= ST_READ;
                  cnt   <= rd_len_m1;
               end else if (pwe) begin
                  state <= ST_SETUP;
                  cnt   <= str_len_m1;
               end else begin
                  state <= ST_XWR;
               end
            end
            ST_READ:   if (cnt == '0) state <= ST_IDLE; else cnt <= cnt - 1'b1;
            ST_SETUP:  state <= ST_STROBE;
            ST_STROBE: if (cnt == '0) state <= ST_HOLD; else cnt <= cnt - 1'b1;
            ST_HOLD:   state <= ST_IDLE;
            ST_XWR:    state <= ST_IDLE;
            default:   state <= ST_IDLE;
         endcase
      end
   end

   assign core_ready = (state == ST_READ && cnt == '0) || state == ST_HOLD || state == ST_XWR;
   assign code_rd    = (state == ST_READ);
   assign code_we    = (state == ST_STROBE);
   assign xdata_we   = (state == ST_XWR);
   assign mem_addr   = addr_q;
   assign mem_data   = data_q;

   // run length of the current read, for the upper bound check
   logic [CNT_W:0] rd_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rd_run <= '0;
      else if (code_rd) rd_run <= rd_run + 1'b1;
      else              rd_run <= '0;
   end

   AST_READ_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      code_rd |-> (int'(rd_run) < READ_MAX)); // R3
   AST_READ_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (code_rd && $past(code_rd)) |-> $stable(mem_addr)); // R3
   AST_SETUP_BEFORE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(code_we) |-> ($stable(mem_addr) && $stable(mem_data))); // R7
   AST_HOLD_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(code_we) |-> (core_ready && $stable(mem_addr) && $stable(mem_data))); // R7
endmodule

// File: rtl/code_wait_ctrl.sv
module code_wait_ctrl #(
   parameter int         ADDR_W     = 16,
   parameter int         DATA_W     = 8,
   parameter int         WS_W       = 3,
   parameter int         STR_W      = 3,
   parameter int         READ_BASE  = 4,
   parameter int         READ_EXTRA = 4,
   parameter int         PWE_BIT    = 4,
   parameter logic [7:0] WS_ADDR    = 8'h92,
   parameter logic [7:0] PC_ADDR    = 8'h87,
   parameter logic [7:0] CK_ADDR    = 8'h8E,
   parameter bit         REG_READ   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sfr_we,
   input  logic [7:0]        sfr_addr,
   input  logic [7:0]        sfr_wdata,
   output logic [7:0]        sfr_rdata,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [ADDR_W-1:0] dptr,
   input  logic [ADDR_W/2-1:0] p2,
   input  logic [ADDR_W/2-1:0] rx,
   input  logic [DATA_W-1:0] acc,
   output logic              core_ready,
   output logic [ADDR_W-1:0] code_addr,
   output logic [DATA_W-1:0] code_wdata,
   output logic              code_rd,
   output logic              code_we,
   output logic [ADDR_W-1:0] xdata_addr,
   output logic [DATA_W-1:0] xdata_wdata,
   output logic              xdata_we
);
   logic [WS_W-1:0]   ws_val;
   logic [STR_W-1:0]  str_val;
   logic              pwe;
   logic [ADDR_W-1:0] sel_addr;
   logic [ADDR_W-1:0] mem_addr;
   logic [DATA_W-1:0] mem_data;

   cwc_sfr_regs #(
      .SFR_AW(8), .SFR_DW(8), .WS_W(WS_W), .STR_W(STR_W), .PWE_BIT(PWE_BIT),
      .RSVD_LOW(3), .WS_ADDR(WS_ADDR), .PC_ADDR(PC_ADDR), .CK_ADDR(CK_ADDR),
      .WS_RESET(8'h07), .PC_RESET(8'h00), .CK_RESET(8'h01), .REG_READ(REG_READ)
   ) i_regs (
      .clk(clk), .rst_n(rst_n), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
      .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
      .ws_val(ws_val), .str_val(str_val), .pwe(pwe)
   );

   cwc_addr_sel #(.ADDR_W(ADDR_W)) i_asel (
      .kind(req_kind), .rd_addr(req_addr), .dptr(dptr),
      .hi_byte(p2), .lo_byte(rx), .addr(sel_addr)
   );

   cwc_seq #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WS_W(WS_W), .STR_W(STR_W),
      .READ_BASE(READ_BASE), .READ_EXTRA(READ_EXTRA)
   ) i_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
      .addr_in(sel_addr), .data_in(acc), .ws_val(ws_val), .str_val(str_val),
      .pwe(pwe), .core_ready(core_ready), .mem_addr(mem_addr), .mem_data(mem_data),
      .code_rd(code_rd), .code_we(code_we), .xdata_we(xdata_we)
   );

   assign code_addr   = mem_addr;
   assign code_wdata  = mem_data;
   assign xdata_addr  = mem_addr;
   assign xdata_wdata = mem_data;

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({code_rd, code_we, xdata_we})); // R8
   AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      core_ready |=> !core_ready); // R10
   AST_XWR_NO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      xdata_we |-> (core_ready && !code_we)); // R8
   AST_PC_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!REG_READ && sfr_addr == PC_ADDR) |-> (sfr_rdata[2:0] == 3'b000)); // R4
   AST_WS_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!REG_READ && sfr_addr == WS_ADDR) |-> (sfr_rdata[7:3] == 5'b0)); // R2
endmodule

// File: tb/test_code_wait_ctrl.sv
module test_code_wait_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sfr_we = 1'b0;
   logic [7:0]  sfr_addr = 8'h00;
   logic [7:0]  sfr_wdata = 8'h00;
   logic [7:0]  sfr_rdata;
   logic        req_valid = 1'b0;
   logic [1:0]  req_kind = 2'b00;
   logic [15:0] req_addr = 16'h0000;
   logic [15:0] dptr = 16'h0000;
   logic [7:0]  p2 = 8'h00;
   logic [7:0]  rx = 8'h00;
   logic [7:0]  acc = 8'h00;
   logic        core_ready, code_rd, code_we, xdata_we;
   logic [15:0] code_addr, xdata_addr;
   logic [7:0]  code_wdata, xdata_wdata;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;
   logic [7:0] m_ws = 8'h07, m_pc = 8'h00, m_ck = 8'h01;

   code_wait_ctrl i_code_wait_ctrl (
      .clk(clk), .rst_n(rst_n), .sfr_we(sfr_we), .sfr_addr(sfr_addr),
      .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .req_valid(req_valid),
      .req_kind(req_kind), .req_addr(req_addr), .dptr(dptr), .p2(p2), .rx(rx),
      .acc(acc), .core_ready(core_ready), .code_addr(code_addr),
      .code_wdata(code_wdata), .code_rd(code_rd), .code_we(code_we),
      .xdata_addr(xdata_addr), .xdata_wdata(xdata_wdata), .xdata_we(xdata_we)
   );

   always #5 clk = ~clk;

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         fails++;
         $display("FAIL watchdog: act=%0d exp<=%0d cycles", cycles, 100000);
         finish_run();
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: act=0x%0h exp=0x%0h", req, act, exp);
      end
   endtask

   function automatic int exp_read_len(input logic [7:0] ws);
      return 4 + ((ws[2:0] > 3'd4) ? 4 : int'(ws[2:0]));
   endfunction

   function automatic logic [7:0] exp_sfr(input logic [7:0] a);
      if (a == 8'h92) return {5'b0, m_ws[2:0]};
      if (a == 8'h8E) return {5'b0, m_ck[2:0]};
      if (a == 8'h87) return {m_pc[7:3], 3'b000};
      return 8'h00;
   endfunction

   task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      sfr_we = 1'b1; sfr_addr = a; sfr_wdata = d;
      @(negedge clk);
      sfr_we = 1'b0;
      if (a == 8'h92) m_ws = d;
      if (a == 8'h8E) m_ck = d;
      if (a == 8'h87) m_pc = d;
   endtask

   task automatic sfr_check(input logic [7:0] a, input string req);
      @(negedge clk);
      sfr_addr = a;
      #1;
      check(sfr_rdata == exp_sfr(a), req, int'(sfr_rdata), int'(exp_sfr(a)));
   endtask

   // runs one access; pwe_x, ws_x, ck_x are the settings the access must use
   task automatic run_access(input logic [1:0] k, input logic [15:0] ra,
                             input bit pwe_x, input logic [7:0] ws_x,
                             input logic [7:0] ck_x);
      int n_rd = 0, n_we = 0, n_xwe = 0, first_we = 0, ready_at = 0, addr_bad = 0;
      logic [15:0] ea;
      ea = (k == 2'b10) ? dptr : (k == 2'b11) ? {p2, rx} : ra;
      @(negedge clk);
      req_valid = 1'b1; req_kind = k; req_addr = ra;
      for (int c = 1; c <= 40 && ready_at == 0; c++) begin
         @(negedge clk);
         if (code_rd) n_rd++;
         if (code_we) begin n_we++; if (first_we == 0) first_we = c; end
         if (xdata_we) begin
            n_xwe++;
            if (xdata_addr != ea || xdata_wdata != acc) addr_bad++;
         end
         if (code_rd && code_addr != ea) addr_bad++;
         if (k[1] && pwe_x && (code_addr != ea || code_wdata != acc)) addr_bad++;
         if (core_ready) ready_at = c;
      end
      req_valid = 1'b0;
      if (!k[1]) begin
         check(ready_at == exp_read_len(ws_x), "R3 read length", ready_at, exp_read_len(ws_x));
         check(n_rd == exp_read_len(ws_x) && n_we == 0 && n_xwe == 0, "R3 code_rd run",
               n_rd, exp_read_len(ws_x));
         check(addr_bad == 0, "R3 read address", addr_bad, 0);
      end else if (pwe_x) begin
         check(ready_at == 4 + int'(ck_x[2:0]), "R7 write length", ready_at, 4 + int'(ck_x[2:0]));
         check(n_we == 2 + int'(ck_x[2:0]) && first_we == 2, "R7 strobe width",
               n_we * 16 + first_we, (2 + int'(ck_x[2:0])) * 16 + 2);
         check(n_xwe == 0 && n_rd == 0, "R7 no other strobe", n_xwe + n_rd, 0);
         check(addr_bad == 0, (k == 2'b10) ? "R5 dptr address/data" : "R6 p2:rx address/data",
               addr_bad, 0);
      end else begin
         check(ready_at == 1 && n_xwe == 1, "R8 data-bus write", ready_at * 16 + n_xwe, 17);
         check(n_we == 0 && n_rd == 0, "R8 code strobe quiet", n_we + n_rd, 0);
         check(addr_bad == 0, "R8 data-bus address/data", addr_bad, 0);
      end
      @(negedge clk);
      check(!core_ready && !code_rd && !code_we && !xdata_we, "R10 idle after ready",
            {core_ready, code_rd, code_we, xdata_we}, 0);
   endtask

   initial begin
      void'($urandom(32'h5EED_0C0D));
      repeat (3) @(negedge clk);
      #1;
      check(!core_ready && !code_rd && !code_we && !xdata_we, "R1 outputs idle",
            {core_ready, code_rd, code_we, xdata_we}, 0);
      rst_n = 1'b1;
      sfr_check(8'h92, "R1 wait-state reset");
      sfr_check(8'h87, "R1 power-control reset");
      sfr_check(8'h8E, "R1 clock-control reset");

      // R2 / R4 register field behaviour
      sfr_write(8'h92, 8'hFD); sfr_check(8'h92, "R2 upper bits read zero");
      sfr_write(8'h87, 8'hFF); sfr_check(8'h87, "R4 reserved bits read zero");
      sfr_write(8'h87, 8'h00); sfr_check(8'h87, "R4 clear");

      // directed R3 corners: ws 0, 4, 5, 7
      acc = 8'h3C; dptr = 16'hBEEF; p2 = 8'h12; rx = 8'h34;
      sfr_write(8'h92, 8'h00); run_access(2'b00, 16'h0100, 0, m_ws, m_ck);
      sfr_write(8'h92, 8'h04); run_access(2'b01, 16'h0200, 0, m_ws, m_ck);
      sfr_write(8'h92, 8'h05); run_access(2'b00, 16'hFFFF, 0, m_ws, m_ck);
      sfr_write(8'h92, 8'h07); run_access(2'b01, 16'h8001, 0, m_ws, m_ck);

      // R8: writes with enable clear
      run_access(2'b10, 16'h0, 0, m_ws, m_ck);
      run_access(2'b11, 16'h0, 0, m_ws, m_ck);

      // R5 / R6 / R7 with stretch 0 and 7
      sfr_write(8'h87, 8'h10);
      sfr_write(8'h8E, 8'h00); run_access(2'b10, 16'h0, 1, m_ws, m_ck);
      sfr_write(8'h8E, 8'h07); run_access(2'b11, 16'h0, 1, m_ws, m_ck);

      // R9: settings changed mid-access apply only to the next one
      sfr_write(8'h92, 8'h07);
      begin
         logic [7:0] old_ws;
         old_ws = m_ws;
         fork
            run_access(2'b00, 16'h4444, 1, old_ws, m_ck);
            begin
               repeat (2) @(negedge clk);
               sfr_we = 1'b1; sfr_addr = 8'h92; sfr_wdata = 8'h00;
               @(negedge clk);
               sfr_we = 1'b0; m_ws = 8'h00;
            end
         join
      end
      run_access(2'b00, 16'h4445, 1, m_ws, m_ck); // R9 new value used
      begin
         logic [7:0] old_ck;
         old_ck = m_ck;
         fork
            run_access(2'b10, 16'h0, 1, m_ws, old_ck);
            begin
               repeat (2) @(negedge clk);
               sfr_we = 1'b1; sfr_addr = 8'h87; sfr_wdata = 8'h00;
               @(negedge clk);
               sfr_we = 1'b0; m_pc = 8'h00;
            end
         join
      end
      run_access(2'b10, 16'h0, 0, m_ws, m_ck); // R9 enable now clear

      // random mix
      for (int i = 0; i < 60; i++) begin
         logic [1:0] k;
         int sel;
         sel = int'($urandom_range(0, 3));
         if (sel == 0) sfr_write(8'h92, 8'($urandom));
         else if (sel == 1) sfr_write(8'h8E, 8'($urandom));
         else if (sel == 2) sfr_write(8'h87, 8'($urandom));
         if (i % 10 == 0) begin
            sfr_check(8'h92, "R2 random readback");
            sfr_check(8'h87, "R4 random readback");
         end
         acc = 8'($urandom); dptr = 16'($urandom); p2 = 8'($urandom); rx = 8'($urandom);
         k = 2'($urandom);
         run_access(k, 16'($urandom), m_pc[4], m_ws, m_ck);
      end
      finish_run();
   end
endmodule